// File: doc/BRIEF.md
# Receive Ring Header Writer

This block sits between a receive byte FIFO and a paged buffer RAM. It steers every arriving frame byte into a circular ring of 256-byte pages through a local address counter. The first four bytes of each frame's first page are kept free while the frame streams in. Once the frame ends and is accepted, the block fills those four bytes with a header: a status byte, the page where the next frame will start, and a 16-bit stored length.

The memory side is either 8 bits or 16 bits wide, set by `cfg_wide`. In 16-bit mode, `cfg_swap` selects which half of each word carries the earlier byte. A rejected frame leaves no header. The address counter goes back to the start of the current page, so the next frame reuses the space. An accepted frame moves the current-page pointer to the next-frame page and raises a one-cycle completion pulse.

The ring runs from page `PSTART` up to, but not including, page `PSTOP`. `cfg_wide` and `cfg_swap` must stay fixed while a frame is in progress.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset, `cur_page` equals `PSTART`, `rx_done` is low and no memory write is issued.
- R2: Frame bytes are stored at consecutive byte addresses starting at offset 4 of page `cur_page`. An address that reaches page `PSTOP` continues at page `PSTART`. Every write falls inside the ring.
- R3: With `cfg_wide`=0, every write has `mem_be`=01 and carries its byte in `mem_wdata[7:0]`. The header occupies offsets 0..3 in this order: status, next page, count low byte, count high byte.
- R4: With `cfg_wide`=1 and `cfg_swap`=0, every write goes to an even address. Low half maps to the even address and high half to the odd address. Frame bytes keep their arrival order. Header offset 0 holds the status and offset 1 holds the next page.
- R5: With `cfg_wide`=1 and `cfg_swap`=1, each pair of frame bytes trades places within its word. A final odd byte goes into the high half with `mem_be`=10. Header offset 0 holds the next page and offset 1 holds the status.
- R6: In every mode, the header count equals the number of frame bytes plus 4. Its low byte is at offset 2 and its high byte at offset 3.
- R7: The next-page value is the page following the last byte written, wrapped from `PSTOP` to `PSTART`. In 16-bit mode an odd-length frame counts as one byte longer.
- R8: For an accepted frame, the header writes follow the end cycle (four cycles in 8-bit mode, two in 16-bit mode). `rx_done` is then high for exactly one cycle, and `cur_page` takes the next-page value in that same cycle. `cur_page` changes at no other time.
- R9: A rejected frame writes no header and leaves `cur_page` unchanged without raising `rx_done`. A pending odd byte in 16-bit mode is dropped. The next frame starts again at offset 4 of the same page.
- R10: A byte offered in the `rx_end` cycle, or while header writes are in progress, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wide | input | 1 | 1: 16-bit memory words, 0: 8-bit |
| cfg_swap | input | 1 | Byte order inside a 16-bit word |
| rx_valid | input | 1 | A frame byte is present on rx_data |
| rx_data | input | 8 | Frame byte |
| rx_end | input | 1 | End of the current frame |
| rx_ok | input | 1 | With rx_end: 1 accepts the frame, 0 rejects it |
| rx_status | input | 8 | With rx_end: status byte for the header |
| mem_we | output | 1 | Buffer RAM write strobe |
| mem_addr | output | 16 | Byte address (even in 16-bit mode) |
| mem_wdata | output | 16 | Write data |
| mem_be | output | 2 | Byte lane enables: bit 0 low half, bit 1 high half |
| cur_page | output | 8 | Page where the next frame will start |
| rx_done | output | 1 | One-cycle pulse when an accepted frame is complete |

## Verification
The assertions check on every cycle that writes stay inside the ring and are word aligned in 16-bit mode. They also check that narrow writes use only the low lane, that `rx_done` is a single-cycle pulse, and that `cur_page` moves only together with it and never leaves the ring. Only the bench's scenarios show that the stored bytes are correct. That covers header placement under each width and byte-order setting, the length and next-page values including a frame that wraps past `PSTOP`, reuse of space after a rejection, and that bytes offered during the end cycle or header writes leave the memory untouched.

// File: rtl/rx_ring_writer.sv
module rx_ring_writer #(
  parameter logic [7:0] PSTART = 8'h40,
  parameter logic [7:0] PSTOP  = 8'h48
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wide,
  input  logic        cfg_swap,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_end,
  input  logic        rx_ok,
  input  logic [7:0]  rx_status,
  output logic        mem_we,
  output logic [15:0] mem_addr,
  output logic [15:0] mem_wdata,
  output logic [1:0]  mem_be,
  output logic [7:0]  cur_page,
  output logic        rx_done
);

  typedef enum logic [2:0] {RUN, H0, H1, H2, H3} st_t;
  st_t st;

  logic [15:0] ptr, cnt, tot_r;
  logic [7:0]  pend, nxt_r, stat_r;
  logic        half;

  function automatic logic [15:0] adv(input logic [15:0] a, input logic [1:0] n);
    logic [15:0] s;
    s = a + {14'd0, n};
    if (s[15:8] == PSTOP) s[15:8] = PSTART;
    return s;
  endfunction

  function automatic logic [7:0] pg_after(input logic [15:0] f);
    logic [7:0] p;
    p = f[15:8] + {7'd0, |f[7:0]};
    if (p == PSTOP) p = PSTART;
    return p;
  endfunction

  wire        run    = (st == RUN);
  wire        take   = run && rx_valid && !rx_end;
  wire        fin_ok = run && rx_end && rx_ok;
  wire        flush  = fin_ok && cfg_wide && half;
  wire [15:0] free   = flush ? adv(ptr, 2'd2) : ptr;
  wire [15:0] base   = {cur_page, 8'h00};
  wire        last_h = cfg_wide ? (st == H1) : (st == H3);

  always_comb begin
    mem_we    = 1'b0;
    mem_addr  = ptr;
    mem_wdata = 16'h0000;
    mem_be    = 2'b00;
    if (take) begin
      if (!cfg_wide) begin
        mem_we    = 1'b1;
        mem_be    = 2'b01;
        mem_wdata = {8'h00, rx_data};
      end else if (half) begin
        mem_we    = 1'b1;
        mem_be    = 2'b11;
        mem_wdata = cfg_swap ? {pend, rx_data} : {rx_data, pend};
      end
    end else if (flush) begin
      mem_we    = 1'b1;
      mem_be    = cfg_swap ? 2'b10 : 2'b01;
      mem_wdata = cfg_swap ? {pend, 8'h00} : {8'h00, pend};
    end else begin
      case (st)
        H0: begin
          mem_we   = 1'b1;
          mem_addr = base;
          if (cfg_wide) begin
            mem_be    = 2'b11;
            mem_wdata = cfg_swap ? {stat_r, nxt_r} : {nxt_r, stat_r};
          end else begin
            mem_be    = 2'b01;
            mem_wdata = {8'h00, stat_r};
          end
        end
        H1: begin
          mem_we = 1'b1;
          if (cfg_wide) begin
            mem_addr  = base + 16'd2;
            mem_be    = 2'b11;
            mem_wdata = tot_r;
          end else begin
            mem_addr  = base + 16'd1;
            mem_be    = 2'b01;
            mem_wdata = {8'h00, nxt_r};
          end
        end
        H2: begin
          mem_we    = 1'b1;
          mem_addr  = base + 16'd2;
          mem_be    = 2'b01;
          mem_wdata = {8'h00, tot_r[7:0]};
        end
        H3: begin
          mem_we    = 1'b1;
          mem_addr  = base + 16'd3;
          mem_be    = 2'b01;
          mem_wdata = {8'h00, tot_r[15:8]};
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= RUN;
      ptr      <= {PSTART, 8'h04};
      cnt      <= 16'd0;
      tot_r    <= 16'd0;
      half     <= 1'b0;
      pend     <= 8'h00;
      nxt_r    <= 8'h00;
      stat_r   <= 8'h00;
      cur_page <= PSTART;
      rx_done  <= 1'b0;
    end else begin
      rx_done <= 1'b0;
      if (run) begin
        if (rx_end) begin
          half <= 1'b0;
          cnt  <= 16'd0;
          if (rx_ok) begin
            nxt_r  <= pg_after(free);
            stat_r <= rx_status;
            tot_r  <= cnt + 16'd4;
            st     <= H0;
          end else begin
            ptr <= {cur_page, 8'h04};
          end
        end else if (rx_valid) begin
          cnt <= cnt + 16'd1;
          if (!cfg_wide) begin
            ptr <= adv(ptr, 2'd1);
          end else if (half) begin
            half <= 1'b0;
            ptr  <= adv(ptr, 2'd2);
          end else begin
            half <= 1'b1;
            pend <= rx_data;
          end
        end
      end else if (last_h) begin
        cur_page <= nxt_r;
        ptr      <= {nxt_r, 8'h04};
        rx_done  <= 1'b1;
        st       <= RUN;
      end else begin
        case (st)
          H0:      st <= H1;
          H1:      st <= H2;
          H2:      st <= H3;
          default: st <= RUN;
        endcase
      end
    end
  end

endmodule

// File: rtl/rx_ring_writer_chk.sv
module rx_ring_writer_chk #(
  parameter logic [7:0] PSTART = 8'h40,
  parameter logic [7:0] PSTOP  = 8'h48
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wide,
  input logic        cfg_swap,
  input logic        rx_valid,
  input logic [7:0]  rx_data,
  input logic        rx_end,
  input logic        rx_ok,
  input logic [7:0]  rx_status,
  input logic        mem_we,
  input logic [15:0] mem_addr,
  input logic [15:0] mem_wdata,
  input logic [1:0]  mem_be,
  input logic [7:0]  cur_page,
  input logic        rx_done
);

  a_r2_write_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr[15:8] >= PSTART && mem_addr[15:8] < PSTOP));

  a_r4_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && cfg_wide) |-> !mem_addr[0]);

  a_r3_low_lane_only: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !cfg_wide) |-> (mem_be == 2'b01));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done);

  a_r8_page_moves_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_page != $past(cur_page)) |-> rx_done);

  a_r7_page_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_page >= PSTART && cur_page < PSTOP));

endmodule

bind rx_ring_writer rx_ring_writer_chk #(.PSTART(PSTART), .PSTOP(PSTOP)) u_chk (.*);

// File: tb/sim_rx_ring_writer.sv
module sim_rx_ring_writer;
  localparam int CLK_NS = 10;
  localparam logic [7:0] PS = 8'h40;
  localparam logic [7:0] PE = 8'h48;
  localparam int RING = (int'(PE) - int'(PS)) * 256;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wide = 1'b0, cfg_swap = 1'b0;
  logic rx_valid = 1'b0, rx_end = 1'b0, rx_ok = 1'b0;
  logic [7:0] rx_data = 8'h00, rx_status = 8'h00;
  wire mem_we;
  wire [15:0] mem_addr, mem_wdata;
  wire [1:0] mem_be;
  wire [7:0] cur_page;
  wire rx_done;

  int checks = 0, errors = 0, exp_cur = 0;
  bit finished = 0;
  byte unsigned dmem[int];
  byte unsigned mmem[int];

  always #(CLK_NS/2) clk = ~clk;

  rx_ring_writer #(.PSTART(PS), .PSTOP(PE)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .cfg_swap(cfg_swap),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_end(rx_end), .rx_ok(rx_ok),
    .rx_status(rx_status), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .cur_page(cur_page), .rx_done(rx_done));

  always @(posedge clk) if (mem_we) begin
    if (mem_be[0]) dmem[int'(mem_addr)] = mem_wdata[7:0];
    if (mem_be[1]) dmem[int'(mem_addr) + 1] = mem_wdata[15:8];
  end

  function automatic int ra(int a);
    return int'(PS) * 256 + (((a - int'(PS) * 256) % RING) + RING) % RING;
  endfunction

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic step(bit exp_done, string r);
    @(posedge clk);
    #1;
    chk(r, int'(rx_done), int'(exp_done));
    chk(r, int'(cur_page), exp_cur);
  endtask

  task automatic cmp_mem(string r);
    int bad = 0;
    checks++;
    if (dmem.size() != mmem.size()) bad++;
    foreach (mmem[a]) if (!dmem.exists(a) || dmem[a] != mmem[a]) bad++;
    if (bad != 0) begin
      errors++;
      $display("FAIL %s memory actual %0d mismatches expected 0 (sizes %0d/%0d)",
               r, bad, dmem.size(), mmem.size());
    end
  endtask

  task automatic frame(int n, bit ok, bit wide, bit swap, int st, int seed);
    int start, nr, fr, nxt, tot, sw;
    byte unsigned prev, v;
    string ht;
    cfg_wide = wide;
    cfg_swap = swap;
    start = exp_cur * 256;
    sw = (wide && swap) ? 1 : 0;
    prev = 0;
    for (int i = 0; i < n; i++) begin
      v = byte'((seed + i * 7) & 255);
      rx_valid = 1'b1;
      rx_data = v;
      step(1'b0, "R2");
      if (!wide) mmem[ra(start + 4 + i)] = v;
      else if (i % 2 == 1) begin
        mmem[ra(start + 4 + ((i - 1) ^ sw))] = prev;
        mmem[ra(start + 4 + (i ^ sw))] = v;
      end
      prev = v;
    end
    rx_valid = 1'b1;
    rx_data = 8'hEE;
    rx_end = 1'b1;
    rx_ok = ok;
    rx_status = 8'(st);
    step(1'b0, "R10");
    rx_end = 1'b0;
    if (ok) begin
      if (wide && (n % 2 == 1)) mmem[ra(start + 4 + ((n - 1) ^ sw))] = prev;
      nr = wide ? ((n + 1) & ~1) : n;
      fr = ra(start + 4 + nr);
      nxt = (fr % 256 == 0) ? fr / 256 : fr / 256 + 1;
      if (nxt == int'(PE)) nxt = int'(PS);
      tot = n + 4;
      mmem[start + (sw ? 1 : 0)] = byte'(st);
      mmem[start + (sw ? 0 : 1)] = byte'(nxt);
      mmem[start + 2] = byte'(tot & 255);
      mmem[start + 3] = byte'(tot >> 8);
      repeat (wide ? 1 : 3) step(1'b0, "R8");
      exp_cur = nxt;
      step(1'b1, "R7");
      rx_valid = 1'b0;
      step(1'b0, "R8");
      ht = !wide ? "R3" : (swap ? "R5" : "R4");
      chk(ht, int'(dmem[start + (sw ? 1 : 0)]), st);
      chk(ht, int'(dmem[start + (sw ? 0 : 1)]), nxt);
      chk("R6", int'(dmem[start + 2]), tot & 255);
      chk("R6", int'(dmem[start + 3]), tot >> 8);
    end else begin
      rx_valid = 1'b0;
      repeat (3) step(1'b0, "R9");
    end
    cmp_mem("R2");
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1", int'(cur_page), int'(PS));
    chk("R1", int'(rx_done), 0);
    chk("R1", int'(mem_we), 0);
    rst_n = 1'b1;
    exp_cur = int'(PS);
    step(1'b0, "R1");

    frame(10, 1, 0, 0, 8'h21, 3);
    frame(5, 0, 0, 0, 8'h00, 90);
    frame(7, 1, 0, 0, 8'h31, 17);
    frame(0, 1, 0, 0, 8'h05, 0);
    frame(300, 1, 0, 0, 8'h41, 55);
    frame(9, 1, 1, 0, 8'h52, 8);
    frame(12, 1, 1, 0, 8'h53, 29);
    frame(7, 1, 1, 1, 8'h64, 71);
    frame(3, 0, 1, 1, 8'h00, 200);
    frame(20, 1, 1, 1, 8'h65, 111);
    frame(700, 1, 0, 0, 8'h76, 13);
    frame(1100, 1, 1, 0, 8'h87, 44);
    frame(501, 1, 1, 1, 8'h98, 77);
    frame(500, 1, 0, 0, 8'hA9, 9);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule